// File: doc/BRIEF.md
# Micro-op Count Grouping Steerer

This block sits at the head of an instruction queue and looks at a window of up to four waiting instructions. Each instruction carries a tag and the number of micro-ops it expands to. In every cycle the block works out how many of these instructions can go to the four parallel decoder slots together. Each accepted instruction is placed in a slot, and the block reports back to the queue how many window entries it took.

Only a fixed set of per-cycle groupings is allowed. These are four single-micro-op instructions, a two-micro-op instruction followed by up to two singles, or one instruction of three or four micro-ops on its own. The group is built greedily in program order and stops at the first instruction that would break the pattern. That instruction then waits for the next cycle.

An instruction of more than four micro-ops never reaches a slot. When it is at the head, it is taken alone and handed to a microcode sequencer through a request that stays raised until the sequencer signals done. Nothing new is accepted until then. A counter records each handoff.

Top module: `uop_group_steer`

## Requirements
- R1: When the head is a single-micro-op instruction (count 0 or 1), the group takes every following single in order, up to four instructions in total.
- R2: When the head has a count of 2, the group takes it into slot 0 and then up to two following singles, so it holds at most three instructions.
- R3: When the head has a count of 3 or 4, it is the only instruction taken in that cycle.
- R4: When the head has a count above 4 and no request is pending, no slot is valid and consume is 1. From the next cycle, ms_req is high with that instruction's tag and count, and it stays high until the cycle in which ms_done is high.
- R5: The group ends at the first instruction that does not fit the pattern begun by the head. For example, 1-2 gives one instruction, 2-2 gives one, and 1-1-3 gives two. The group also ends at the first entry whose win_valid bit is low, and every later entry is ignored.
- R6: While ms_req is high, consume is 0 and no slot is valid. This holds in the ms_done cycle as well, and instructions are accepted again from the following cycle.
- R7: consume is 0 when win_valid[0] is low. Apart from the microcode handoff in R4, consume equals the number of valid slots.
- R8: Slot i (fields at bits [i*TAG_W +: TAG_W] and [i*UOP_W +: UOP_W]) carries the tag and count of window entry i. The valid slots always form a prefix starting at slot 0, and unused slots have their valid bit low.
- R9: ms_switches increments by exactly one on each handoff to the microcode sequencer.
- R10: A synchronous active-high rst clears the pending request and ms_switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 4 | Valid bit for each window entry, with entry 0 as the oldest |
| win_tag | input | 4*TAG_W | Tag of each window entry |
| win_uops | input | 4*UOP_W | Micro-op count of each window entry |
| consume | output | 3 | Number of entries taken from the window this cycle |
| slot_valid | output | 4 | Valid bit for each decoder slot |
| slot_tag | output | 4*TAG_W | Tag for each decoder slot |
| slot_uops | output | 4*UOP_W | Micro-op count for each decoder slot |
| ms_req | output | 1 | Microcode sequencer request, held until done |
| ms_tag | output | TAG_W | Tag of the instruction handed to the sequencer |
| ms_uops | output | UOP_W | Micro-op count of that instruction |
| ms_done | input | 1 | Sequencer done, which releases the request |
| ms_switches | output | CNT_W | Number of handoffs to the sequencer |

## Verification
The checker looks at every cycle for the following properties. The valid slots must form a prefix. A lone three- or four-micro-op group must stay alone, and slot 1 may only hold a single. The block must stall fully while a request is pending, the request must stay held until done, and the counter must step when a request rises. consume must also match the slot count. The exact group size for each pattern of counts and valid bits can only be shown by the bench's sweep. So can tag routing, release timing after done, and reset during a pending request. The sweep covers every count from 1 to 5 in all four entries, at every valid-prefix length.

// File: rtl/uop_group_steer.sv
module uop_group_steer #(
  parameter int TAG_W = 8,
  parameter int UOP_W = 4,
  parameter int CNT_W = 16,
  parameter int MAX_DIRECT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         win_valid,
  input  logic [4*TAG_W-1:0] win_tag,
  input  logic [4*UOP_W-1:0] win_uops,
  output logic [2:0]         consume,
  output logic [3:0]         slot_valid,
  output logic [4*TAG_W-1:0] slot_tag,
  output logic [4*UOP_W-1:0] slot_uops,
  output logic               ms_req,
  output logic [TAG_W-1:0]   ms_tag,
  output logic [UOP_W-1:0]   ms_uops,
  input  logic               ms_done,
  output logic [CNT_W-1:0]   ms_switches
);

  logic [3:0] vpre, single;
  logic       busy, head_mc, take_mc;
  logic [2:0] grp;

  assign vpre[0] = win_valid[0];
  for (genvar i = 0; i < 4; i++) begin : g_ent
    if (i > 0) begin : g_pre
      assign vpre[i] = vpre[i-1] & win_valid[i];
    end
    assign single[i] = win_uops[i*UOP_W +: UOP_W] <= UOP_W'(1);
    assign slot_valid[i] = 3'(i) < grp;
  end

  assign head_mc = vpre[0] && (win_uops[UOP_W-1:0] > UOP_W'(MAX_DIRECT));
  assign take_mc = head_mc && !busy;

  always_comb begin
    grp = 3'd0;
    if (!busy && vpre[0] && !head_mc) begin
      grp = 3'd1;
      if (win_uops[UOP_W-1:0] == UOP_W'(2)) begin
        if (vpre[1] && single[1]) begin
          grp = 3'd2;
          if (vpre[2] && single[2]) grp = 3'd3;
        end
      end else if (single[0]) begin
        if (vpre[1] && single[1]) begin
          grp = 3'd2;
          if (vpre[2] && single[2]) begin
            grp = 3'd3;
            if (vpre[3] && single[3]) grp = 3'd4;
          end
        end
      end
    end
  end

  assign consume   = take_mc ? 3'd1 : grp;
  assign slot_tag  = win_tag;
  assign slot_uops = win_uops;
  assign ms_req    = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      ms_switches <= '0;
      ms_tag      <= '0;
      ms_uops     <= '0;
    end else if (take_mc) begin
      busy        <= 1'b1;
      ms_tag      <= win_tag[TAG_W-1:0];
      ms_uops     <= win_uops[UOP_W-1:0];
      ms_switches <= ms_switches + 1'b1;
    end else if (busy && ms_done) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/uop_group_steer_chk.sv
module uop_group_steer_chk #(
  parameter int UOP_W = 4,
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         consume,
  input logic [3:0]         slot_valid,
  input logic [4*UOP_W-1:0] slot_uops,
  input logic               ms_req,
  input logic               ms_done,
  input logic [CNT_W-1:0]   ms_switches
);

  a_r8_slot_prefix: assert property (@(posedge clk) disable iff (rst)
    slot_valid inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});

  a_r6_stall_no_issue: assert property (@(posedge clk) disable iff (rst)
    ms_req |-> (consume == 3'd0 && slot_valid == 4'b0000));

  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (ms_req && !ms_done) |=> ms_req);

  a_r9_count_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(ms_req) |-> ms_switches == $past(ms_switches) + 1'b1);

  a_r3_alone: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[0] && slot_uops[UOP_W-1:0] >= UOP_W'(3)) |-> slot_valid[3:1] == 3'b000);

  a_r2_second_single: assert property (@(posedge clk) disable iff (rst)
    slot_valid[1] |-> slot_uops[2*UOP_W-1:UOP_W] <= UOP_W'(1));

  a_r7_consume_match: assert property (@(posedge clk) disable iff (rst)
    (slot_valid != 4'b0000) |-> 32'(consume) == $countones(slot_valid));

endmodule

bind uop_group_steer uop_group_steer_chk #(.UOP_W(UOP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .consume(consume), .slot_valid(slot_valid),
  .slot_uops(slot_uops), .ms_req(ms_req), .ms_done(ms_done), .ms_switches(ms_switches));

// File: tb/uop_group_steer_tb.sv
module uop_group_steer_tb;
  localparam int TAG_W = 8;
  localparam int UOP_W = 4;
  localparam int CNT_W = 16;

  logic               clk = 0;
  logic               rst = 1;
  logic [3:0]         win_valid = 0;
  logic [4*TAG_W-1:0] win_tag = 0;
  logic [4*UOP_W-1:0] win_uops = 0;
  logic [2:0]         consume;
  logic [3:0]         slot_valid;
  logic [4*TAG_W-1:0] slot_tag;
  logic [4*UOP_W-1:0] slot_uops;
  logic               ms_req;
  logic [TAG_W-1:0]   ms_tag;
  logic [UOP_W-1:0]   ms_uops;
  logic               ms_done = 0;
  logic [CNT_W-1:0]   ms_switches;

  int n_chk = 0, n_fail = 0, exp_sw = 0;

  always #10 clk = ~clk;

  uop_group_steer #(.TAG_W(TAG_W), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Arithmetic group model: returns slots taken, flags microcode head
  function automatic int model(input int vlen, input int u[4], output bit mc);
    int k;
    mc = 0;
    if (vlen == 0) return 0;
    if (u[0] > 4) begin mc = 1; return 0; end
    if (u[0] >= 3) return 1;
    k = 1;
    for (int i = 1; i < vlen; i++) begin
      if (u[i] > 1) break;
      if (u[0] == 2 && k == 3) break;
      k++;
    end
    return k;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ms_req == 0, "R10 reset ms_req", ms_req, 0);
    chk(ms_switches == 0, "R10 reset counter", ms_switches, 0);
    rst = 0;
    win_valid = 4'b0000;
    #1;
    chk(consume == 0, "R7 empty head consume", consume, 0);
    chk(slot_valid == 0, "R8 empty slots", slot_valid, 0);
    @(negedge clk);

    for (int code = 0; code < 625; code++) begin
      for (int vlen = 0; vlen <= 4; vlen++) begin
        int u[4];
        int c, en, ec;
        bit mc;
        c = code;
        for (int i = 0; i < 4; i++) begin
          u[i] = (c % 5) + 1;
          c = c / 5;
          win_uops[i*UOP_W +: UOP_W] = UOP_W'(u[i]);
          win_tag[i*TAG_W +: TAG_W]  = TAG_W'(code * 4 + i + vlen);
        end
        // entries past the prefix: odd pattern so they must be ignored (R5)
        win_valid = 4'((1 << vlen) - 1) | (vlen < 3 ? 4'b1000 : 4'b0000);
        en = model(vlen, u, mc);
        ec = mc ? 1 : en;
        #1;
        chk(consume == 3'(ec), u[0] > 4 ? "R4 handoff consume" :
            u[0] >= 3 ? "R3 alone consume" : u[0] == 2 ? "R2 pair group" :
            "R1 single group", consume, ec);
        chk(slot_valid == 4'((1 << en) - 1), "R5 R8 slot valid prefix", slot_valid, (1 << en) - 1);
        for (int i = 0; i < en; i++)
          chk(slot_tag[i*TAG_W +: TAG_W] == win_tag[i*TAG_W +: TAG_W] &&
              slot_uops[i*UOP_W +: UOP_W] == UOP_W'(u[i]), "R8 slot routing",
              slot_tag[i*TAG_W +: TAG_W], win_tag[i*TAG_W +: TAG_W]);
        @(posedge clk);
        @(negedge clk);
        if (mc) begin
          exp_sw++;
          chk(ms_req == 1, "R4 request raised", ms_req, 1);
          chk(ms_tag == win_tag[TAG_W-1:0], "R4 request tag", ms_tag, win_tag[TAG_W-1:0]);
          chk(ms_uops == UOP_W'(u[0]), "R4 request count", ms_uops, u[0]);
          chk(ms_switches == CNT_W'(exp_sw), "R9 switch count", ms_switches, exp_sw);
          chk(consume == 0 && slot_valid == 0, "R6 stall", consume, 0);
          @(posedge clk);
          @(negedge clk);
          chk(ms_req == 1, "R4 request held", ms_req, 1);
          ms_done = 1;
          #1;
          chk(consume == 0, "R6 stall in done cycle", consume, 0);
          @(posedge clk);
          @(negedge clk);
          ms_done = 0;
          chk(ms_req == 0, "R6 release after done", ms_req, 0);
          #1;
          chk(consume == 1, "R6 accepting again", consume, 1);
        end
      end
    end

    win_valid = 4'b0001;
    win_uops[UOP_W-1:0] = UOP_W'(7);
    @(posedge clk);
    @(negedge clk);
    chk(ms_req == 1, "R4 request before reset", ms_req, 1);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk(ms_req == 0, "R10 reset clears request", ms_req, 0);
    chk(ms_switches == 0, "R10 reset clears counter", ms_switches, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule